// File: doc/BRIEF.md
# Programmable-logic reset sequencer

This block prepares the programmable fabric for a configuration load and puts it back into service afterwards. On a start pulse for a full load it holds every fabric reset line active and opens the level shifters in the processor-to-fabric direction only. It then pulses the active-low program line and confirms that the fabric's clear-status input follows each step. The sequence ends with a verified rising edge on that status. The block then stays busy while the image is streamed in by other logic.

When the loader asks it to finish, it polls a load-done input. On success it opens the level shifters in both directions and then releases the fabric resets. A partial load skips all preparation and restore steps and leaves every output alone. Every wait is sampled once per poll interval. A wait that runs out of polls stops the sequence with an error and a timeout flag.

Top module: `pl_reset_seq`

## Requirements
- R1: After reset, busy, error and timeout are 0, the program line is 1, the fabric reset vector is 0x0 and the level-shifter vector is 0x0.
- R2: A start with the partial flag set leaves the program line, the fabric reset vector and the level-shifter vector unchanged from start until the block is idle again.
- R3: A full start drives the fabric reset vector to 0xF one cycle after the start edge. The level-shifter vector becomes 0x0 one cycle later and 0xA one cycle after that. The value 0xA never appears unless the reset vector is 0xF. While the load is in progress the outputs hold at resets 0xF, shifters 0xA and program line 1.
- R4: In a full start the program line is set to 1, then taken to 0 only after the synchronized clear-status input is seen 1, then returned to 1 only after it is seen 0, and the sequence waits for it to be 1 again. That gives exactly one low pulse. The clear-status input passes through two flip-flops before it is sampled.
- R5: Each wait samples its condition once every POLL_CYC cycles. If the condition is still false at poll number TIMEOUT_POLLS, exactly POLL_CYC*TIMEOUT_POLLS cycles after the wait began, the block sets error and timeout, drops busy and keeps its outputs as they are.
- R6: After a finish request in a full load, once load-done is seen on a poll, the level-shifter vector becomes 0xF and the fabric reset vector then becomes 0x0 one cycle later, and busy drops.
- R7: The wait for load-done uses the same poll interval and timeout as the other waits.
- R8: Busy rises on the start edge and stays 1 until the block is idle. Error and timeout stay set while idle and clear on the next start.
- R9: A start pulse while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin a load |
| partial_i | input | 1 | Load is a partial reconfiguration (sampled with start) |
| fab_clear_i | input | 1 | Asynchronous clear-status from the fabric |
| load_done_i | input | 1 | Fabric reports configuration complete |
| finish_i | input | 1 | One-cycle request to run the restore step |
| fab_prog_n_o | output | 1 | Active-low program line to the fabric |
| fab_rst_o | output | 4 | Fabric reset lines, 1 = held in reset |
| lvl_en_o | output | 4 | Level-shifter enables |
| busy_o | output | 1 | Sequence in progress |
| err_o | output | 1 | Last sequence ended in failure |
| timeout_o | output | 1 | Last sequence ended because a wait ran out |

## Verification
The hardest situation to reach is a timeout in the middle of the program pulse, after the line has gone low. The fabric has to keep reporting "cleared" although the line is low. The bench gets there with a fabric model that can hold the clear-status input at a fixed level rather than echo the program line after a random delay. It counts cycles from the falling edge to the error flag. A second stuck case withholds load-done after a finish request. A partial load run right after such a failure then shows that the odd left-over output values are kept untouched.

// File: rtl/pl_seq_pkg.sv
package pl_seq_pkg;

    localparam int VEC_W = 4;

    localparam logic [VEC_W-1:0] RST_ALL   = 4'hF;
    localparam logic [VEC_W-1:0] RST_NONE  = 4'h0;
    localparam logic [VEC_W-1:0] LVL_OFF   = 4'h0;
    localparam logic [VEC_W-1:0] LVL_P2L   = 4'hA;
    localparam logic [VEC_W-1:0] LVL_BOTH  = 4'hF;

    typedef enum logic [3:0] {
        S_IDLE,
        S_LS_OFF,
        S_LS_P2L,
        S_WAIT_HI1,
        S_WAIT_LO,
        S_WAIT_HI2,
        S_LOAD,
        S_WAIT_DONE,
        S_REL_RST
    } seq_state_e;

    typedef struct packed {
        seq_state_e       state;
        logic             part;
        logic             prog_n;
        logic [VEC_W-1:0] fab;
        logic [VEC_W-1:0] lvl;
        logic             busy;
        logic             err;
        logic             tmo;
    } seq_regs_t;

endpackage

// File: rtl/pl_sync2.sv
module pl_sync2 #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic meta_q, meta_d;
    logic out_q, out_d;

    always_comb begin
        meta_d = async_i;
        out_d  = meta_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            out_q  <= RST_VAL;
        end else begin
            meta_q <= meta_d;
            out_q  <= out_d;
        end
    end

    assign sync_o = out_q;
endmodule

// File: rtl/pl_poll_timer.sv
module pl_poll_timer #(
    parameter int POLL_CYC      = 2000,
    parameter int TIMEOUT_POLLS = 125000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic clr_i,
    output logic tick_o,
    output logic last_o
);
    localparam int CYC_W  = (POLL_CYC > 2) ? $clog2(POLL_CYC) : 1;
    localparam int POLL_W = $clog2(TIMEOUT_POLLS + 1);
    localparam logic [CYC_W-1:0]  CYC_LAST  = CYC_W'(POLL_CYC - 1);
    localparam logic [POLL_W-1:0] POLL_LAST = POLL_W'(TIMEOUT_POLLS - 1);

    logic [CYC_W-1:0]  cyc_d, cyc_q;
    logic [POLL_W-1:0] poll_d, poll_q;

    assign tick_o = run_i && (cyc_q == CYC_LAST);
    assign last_o = tick_o && (poll_q == POLL_LAST);

    always_comb begin
        cyc_d  = cyc_q;
        poll_d = poll_q;
        if (!run_i || clr_i) begin
            cyc_d  = '0;
            poll_d = '0;
        end else if (cyc_q == CYC_LAST) begin
            cyc_d  = '0;
            poll_d = poll_q + 1'b1;
        end else begin
            cyc_d = cyc_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc_q  <= '0;
            poll_q <= '0;
        end else begin
            cyc_q  <= cyc_d;
            poll_q <= poll_d;
        end
    end

    generate
        if (POLL_CYC > 1) begin : g_gap_chk
            AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
                tick_o |=> !tick_o); // R5
        end
    endgenerate
endmodule

// File: rtl/pl_reset_seq.sv
module pl_reset_seq
    import pl_seq_pkg::*;
#(
    parameter int POLL_CYC      = 2000,
    parameter int TIMEOUT_POLLS = 125000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             partial_i,
    input  logic             fab_clear_i,
    input  logic             load_done_i,
    input  logic             finish_i,
    output logic             fab_prog_n_o,
    output logic [VEC_W-1:0] fab_rst_o,
    output logic [VEC_W-1:0] lvl_en_o,
    output logic             busy_o,
    output logic             err_o,
    output logic             timeout_o
);
    seq_regs_t d, q;
    logic      clear_s;
    logic      tick, last, waiting, clr;

    pl_sync2 #(.RST_VAL(1'b0)) i_clear_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (fab_clear_i),
        .sync_o  (clear_s)
    );

    assign waiting = (q.state == S_WAIT_HI1) || (q.state == S_WAIT_LO) ||
                     (q.state == S_WAIT_HI2) || (q.state == S_WAIT_DONE);

    pl_poll_timer #(
        .POLL_CYC      (POLL_CYC),
        .TIMEOUT_POLLS (TIMEOUT_POLLS)
    ) i_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (waiting),
        .clr_i  (clr),
        .tick_o (tick),
        .last_o (last)
    );

    always_comb begin
        d   = q;
        clr = 1'b0;
        unique case (q.state)
            S_IDLE: begin
                if (start_i) begin
                    d.err  = 1'b0;
                    d.tmo  = 1'b0;
                    d.busy = 1'b1;
                    d.part = partial_i;
                    if (partial_i) begin
                        d.state = S_LOAD;
                    end else begin
                        d.fab   = RST_ALL;
                        d.state = S_LS_OFF;
                    end
                end
            end
            S_LS_OFF: begin
                d.lvl   = LVL_OFF;
                d.state = S_LS_P2L;
            end
            S_LS_P2L: begin
                d.lvl    = LVL_P2L;
                d.prog_n = 1'b1;
                d.state  = S_WAIT_HI1;
            end
            S_WAIT_HI1: begin
                if (tick && clear_s) begin
                    d.prog_n = 1'b0;
                    d.state  = S_WAIT_LO;
                    clr      = 1'b1;
                end
            end
            S_WAIT_LO: begin
                if (tick && !clear_s) begin
                    d.prog_n = 1'b1;
                    d.state  = S_WAIT_HI2;
                    clr      = 1'b1;
                end
            end
            S_WAIT_HI2: begin
                if (tick && clear_s) d.state = S_LOAD;
            end
            S_LOAD: begin
                if (finish_i) d.state = S_WAIT_DONE;
            end
            S_WAIT_DONE: begin
                if (tick && load_done_i) begin
                    if (q.part) begin
                        d.state = S_IDLE;
                        d.busy  = 1'b0;
                    end else begin
                        d.lvl   = LVL_BOTH;
                        d.state = S_REL_RST;
                    end
                end
            end
            S_REL_RST: begin
                d.fab   = RST_NONE;
                d.state = S_IDLE;
                d.busy  = 1'b0;
            end
            default: d.state = S_IDLE;
        endcase

        // a wait that reaches its final poll unsatisfied aborts the run
        if (waiting && last && (d.state == q.state)) begin
            d.state = S_IDLE;
            d.busy  = 1'b0;
            d.err   = 1'b1;
            d.tmo   = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state  <= S_IDLE;
            q.part   <= 1'b0;
            q.prog_n <= 1'b1;
            q.fab    <= RST_NONE;
            q.lvl    <= LVL_OFF;
            q.busy   <= 1'b0;
            q.err    <= 1'b0;
            q.tmo    <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign fab_prog_n_o = q.prog_n;
    assign fab_rst_o    = q.fab;
    assign lvl_en_o     = q.lvl;
    assign busy_o       = q.busy;
    assign err_o        = q.err;
    assign timeout_o    = q.tmo;

    AST_PARTIAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && q.part) |-> ($stable(q.fab) && $stable(q.lvl) && $stable(q.prog_n))); // R2
    AST_P2L_UNDER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        (q.lvl == LVL_P2L) |-> (q.fab == RST_ALL)); // R3
    AST_PROG_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.prog_n) |-> $past(clear_s)); // R4
    AST_RELEASE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(q.fab) == RST_ALL) && (q.fab == RST_NONE)) |-> (q.lvl == LVL_BOTH)); // R6
    AST_ERR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        q.err |-> !q.busy); // R8
endmodule

// File: tb/test_pl_reset_seq.sv
module test_pl_reset_seq;
    localparam int P = 4;
    localparam int N = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0, partial_i = 1'b0, finish_i = 1'b0, load_done_i = 1'b0;
    logic fab_clear_i;
    logic fab_prog_n_o, busy_o, err_o, timeout_o;
    logic [3:0] fab_rst_o, lvl_en_o;

    int checks = 0, errors = 0;
    bit finished = 0;

    // fabric model: echo program line after a delay, or hold a fixed level
    logic [15:0] hist = '1;
    int  dly = 0;
    bit  stuck = 0;
    logic stuck_val = 1'b1;

    always @(posedge clk) hist <= {hist[14:0], fab_prog_n_o};
    always @* begin
        if (stuck)         fab_clear_i = stuck_val;
        else if (dly == 0) fab_clear_i = fab_prog_n_o;
        else               fab_clear_i = hist[dly-1];
    end

    // order monitors
    int  falls = 0, rises = 0, bad_order = 0, bad_rel = 0;
    bit  seen_lvl0 = 0;
    logic prev_prog = 1'b1;
    logic [3:0] prev_fab = 4'h0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_prog && !fab_prog_n_o) falls++;
            if (!prev_prog && fab_prog_n_o) rises++;
            if (lvl_en_o == 4'hA && fab_rst_o != 4'hF) bad_order++;
            if (prev_fab == 4'hF && fab_rst_o == 4'h0 && lvl_en_o != 4'hF) bad_rel++;
            if (lvl_en_o == 4'h0) seen_lvl0 = 1;
        end
        prev_prog = fab_prog_n_o;
        prev_fab  = fab_rst_o;
    end

    pl_reset_seq #(.POLL_CYC(P), .TIMEOUT_POLLS(N)) i_pl_reset_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .partial_i    (partial_i),
        .fab_clear_i  (fab_clear_i),
        .load_done_i  (load_done_i),
        .finish_i     (finish_i),
        .fab_prog_n_o (fab_prog_n_o),
        .fab_rst_o    (fab_rst_o),
        .lvl_en_o     (lvl_en_o),
        .busy_o       (busy_o),
        .err_o        (err_o),
        .timeout_o    (timeout_o)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int outs_word();
        return {fab_prog_n_o, fab_rst_o, lvl_en_o};
    endfunction

    // expected prep result for a full load
    function automatic int exp_load_word();
        return {1'b1, 4'hF, 4'hA};
    endfunction

    task automatic do_start(input bit part);
        partial_i = part;
        start_i   = 1'b1;
        @(negedge clk);
        start_i   = 1'b0;
        partial_i = 1'b0;
    endtask

    task automatic do_finish();
        finish_i = 1'b1;
        @(negedge clk);
        finish_i = 1'b0;
    endtask

    task automatic go_load(input int d, input bit poke);
        logic pp;
        pp = fab_prog_n_o;
        stuck = 0; dly = d;
        falls = 0; rises = 0; seen_lvl0 = 0;
        do_start(1'b0);
        chk(busy_o && !err_o && !timeout_o, "R8 start", {busy_o, err_o, timeout_o}, 3'b100);
        chk(fab_rst_o == 4'hF, "R3 resets first", fab_rst_o, 4'hF);
        repeat (30) @(negedge clk);
        if (poke) begin
            do_start(1'b1);
            do_start(1'b0);
        end
        repeat (30) @(negedge clk);
        chk(outs_word() == exp_load_word(), "R3 load outputs", outs_word(), exp_load_word());
        chk(busy_o && !err_o, "R8 busy in load", {busy_o, err_o}, 2'b10);
        chk(falls == 1, "R4 one low pulse", falls, 1);
        chk(rises == (pp ? 1 : 2), "R4 rises", rises, pp ? 1 : 2);
        chk(seen_lvl0 && bad_order == 0, "R3 shifter order", bad_order, 0);
        if (poke) chk(falls == 1, "R9 start ignored while busy", falls, 1);
    endtask

    task automatic finish_with(input int dd, input bit part);
        int n;
        do_finish();
        repeat (dd) @(negedge clk);
        load_done_i = 1'b1;
        n = 0;
        while (busy_o && n < 40) begin
            @(negedge clk);
            n++;
        end
        load_done_i = 1'b0;
        chk(!busy_o && !err_o && !timeout_o, part ? "R2 partial finish" : "R6 finish flags",
            {busy_o, err_o, timeout_o}, 0);
    endtask

    task automatic run_full(input int d, input int dd, input bit poke);
        go_load(d, poke);
        bad_rel = 0;
        finish_with(dd, 1'b0);
        chk(fab_rst_o == 4'h0 && lvl_en_o == 4'hF, "R6 restore values",
            {fab_rst_o, lvl_en_o}, 8'h0F);
        chk(bad_rel == 0, "R6 release after shifters", bad_rel, 0);
    endtask

    task automatic run_partial(input int dd);
        int snap;
        snap = outs_word();
        falls = 0;
        do_start(1'b1);
        chk(busy_o && !err_o, "R2 partial busy", {busy_o, err_o}, 2'b10);
        repeat (12) @(negedge clk);
        chk(outs_word() == snap, "R2 partial untouched", outs_word(), snap);
        finish_with(dd, 1'b1);
        chk(outs_word() == snap && falls == 0, "R2 partial after finish", outs_word(), snap);
    endtask

    task automatic tmo_init();
        int n, w;
        dly = 0; stuck = 1; stuck_val = 1'b1;
        do_start(1'b0);
        w = 0;
        while (fab_prog_n_o && w < 60) begin
            @(negedge clk);
            w++;
        end
        n = 0;
        while (!err_o && n < 100) begin
            @(negedge clk);
            n++;
        end
        chk(n == P * N, "R5 timeout cycles", n, P * N);
        chk(timeout_o && !busy_o, "R5 timeout flags", {timeout_o, busy_o}, 2'b10);
        chk(!fab_prog_n_o && fab_rst_o == 4'hF && lvl_en_o == 4'hA, "R5 outputs held",
            outs_word(), {1'b0, 4'hF, 4'hA});
        stuck = 0;
        repeat (5) @(negedge clk);
        chk(err_o && timeout_o, "R8 error sticky", {err_o, timeout_o}, 2'b11);
    endtask

    task automatic tmo_done();
        int n;
        go_load(2, 1'b0);
        do_finish();
        n = 0;
        while (!err_o && n < 100) begin
            @(negedge clk);
            n++;
        end
        chk(n == P * N, "R7 done timeout cycles", n, P * N);
        chk(!busy_o && timeout_o && outs_word() == exp_load_word(), "R7 done timeout state",
            outs_word(), exp_load_word());
    endtask

    initial begin
        int seed;
        seed = $urandom(32'd4242);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy_o && !err_o && !timeout_o, "R1 reset flags", {busy_o, err_o, timeout_o}, 0);
        chk(outs_word() == {1'b1, 4'h0, 4'h0}, "R1 reset outputs", outs_word(), 9'h100);

        run_full(0, 0, 1'b0);
        run_full(6, 8, 1'b1);
        tmo_init();
        run_partial(3);
        run_full(3, 2, 1'b0);
        tmo_done();
        run_partial(0);
        for (int i = 0; i < 10; i++) begin
            int d, dd;
            d  = $urandom_range(0, 6);
            dd = $urandom_range(0, 8);
            if ($urandom_range(0, 2) == 0) run_partial(dd);
            else run_full(d, dd, $urandom_range(0, 1) == 1);
        end

        finished = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(2_000_000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule